// File: doc/BRIEF.md
# Bit-Serial Accumulating Adder

This block adds two WIDTH-bit operands one bit position per clock using a single full adder and a carry flip-flop. Operand A and operand B each live in a right-shifting register. On every shift clock the full adder combines the low bit of A, the low bit of B and the stored carry. The resulting sum bit enters the top of A as A shifts right, so after WIDTH clocks A holds the sum in place of the original operand. Register B shifts right in step with A and takes a fresh bit from an external serial line at its top. After WIDTH shifts, B holds the word that was streamed in, ready to be the next addend.

Software-free use is simple. Parallel-load one or both operands while the block is idle, pulse `start`, and wait for `done`. Then read `result` and `carry_out`. Because A keeps the sum, a chain of additions accumulates naturally: reload only B, or stream B in serially, and start again.

Top module: `bit_serial_adder`

## Requirements
- R1: After reset, `result` is 0, `carry_out` is 0, `done` is 0 and `shifting` is 0.
- R2: While `shifting` is 0, a cycle with `load_a` high makes `result` equal `a_in` after the next clock edge, and a cycle with `load_b` high stores `b_in` as operand B. With neither load high and no shift in progress, `result` holds its value.
- R3: A `start` accepted while idle makes `shifting` high from the next edge for exactly WIDTH cycles. When it drops, `done` rises in the same cycle, and `done` and `shifting` are never high together.
- R4: When `done` rises, `result` equals (A + B) mod 2^WIDTH and `carry_out` equals bit WIDTH of A + B, using the operands present when the addition began.
- R5: The carry flip-flop is cleared when an addition is accepted, so a carry left over from an earlier addition never enters the next one.
- R6: During the k-th shift (k counted from 0), bit k of operand B's new value is taken from `ser_in`. After the addition, B equals the word whose bit k was driven on `ser_in` during shift k.
- R7: A `start` pulse that arrives while `shifting` is high is ignored: neither the shift length nor the result changes.
- R8: `load_a` and `load_b` are ignored while `shifting` is high.
- R9: `done` clears on the edge that accepts a new `start` and otherwise stays high until then.
- R10: After shift k (k from 0), `result[WIDTH-1]` equals bit k of A + B. For A = 0100 and B = 0111 these bits are 1, 1, 0, 1 and the final result is 1011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_a | input | 1 | Parallel-load operand A from `a_in` (idle only) |
| load_b | input | 1 | Parallel-load operand B from `b_in` (idle only) |
| a_in | input | WIDTH | Parallel value for operand A |
| b_in | input | WIDTH | Parallel value for operand B |
| start | input | 1 | Begin an addition (accepted only when idle) |
| ser_in | input | 1 | Serial bit entering the top of operand B on each shift |
| result | output | WIDTH | Contents of register A (the sum once `done` is high) |
| carry_out | output | 1 | Carry flip-flop, the final carry once `done` is high |
| shifting | output | 1 | High during the WIDTH shift cycles |
| done | output | 1 | Addition complete, held until the next start |

## Verification
The bench runs every operand pair of a 4-bit build. A design that mis-routed the carry would get sums wrong wherever a carry crosses positions, for example 1111 + 0001. One that shifted one cycle too many or too few would rotate the result and raise `done` at the wrong cycle. A stale-carry test follows a carry-producing addition with 0 + 0; a design that failed to clear the carry would return 1 instead of 0. Extra `start` and `load_a` pulses are injected mid-shift, where honouring either would cut the operation short or corrupt A. An addition that reloads only A checks that B kept the bits streamed in through `ser_in` in the right order.

// File: rtl/serial_add_pkg.sv
package serial_add_pkg;

    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_SHIFT = 1'b1
    } phase_t;

    typedef struct packed {
        logic carry;
        logic sum;
    } fa_out_t;

    function automatic fa_out_t add_bits(input logic x, input logic y, input logic ci);
        fa_out_t r;
        r.sum   = x ^ y ^ ci;
        r.carry = (x & y) | (ci & (x ^ y));
        return r;
    endfunction

endpackage

// File: rtl/fa_cell.sv
module fa_cell
    import serial_add_pkg::*;
(
    input  logic    x,
    input  logic    y,
    input  logic    ci,
    output fa_out_t o
);
    assign o = add_bits(x, y, ci);
endmodule

// File: rtl/rshift_reg.sv
module rshift_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             shift,
    input  logic             ser_in,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] shifted;

    generate
        for (genvar i = 0; i < WIDTH - 1; i++) begin : g_move
            assign shifted[i] = q[i+1];
        end
    endgenerate
    assign shifted[WIDTH-1] = ser_in;

    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (load)  q <= load_val;
        else if (shift) q <= shifted;
    end

    // R2: with neither load nor shift the register keeps its contents
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!load && !shift) |=> $stable(q));
endmodule

// File: rtl/serial_seq_ctrl.sv
module serial_seq_ctrl
    import serial_add_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic shifting,
    output logic done,
    output logic accept
);
    localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    phase_t        phase;
    logic [CW-1:0] cnt;
    logic          last;

    assign shifting = (phase == PH_SHIFT);
    assign accept   = start && (phase == PH_IDLE);
    assign last     = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else if (accept) begin
            phase <= PH_SHIFT;
            cnt   <= '0;
            done  <= 1'b0;
        end else if (phase == PH_SHIFT) begin
            if (last) begin
                phase <= PH_IDLE;
                done  <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assert_done_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(done && shifting));
    assert_end_R3: assert property (@(posedge clk) disable iff (rst)
        (shifting && last) |=> (!shifting && done));
    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (shifting && !last && start) |=> shifting);
    assert_done_clear_R9: assert property (@(posedge clk) disable iff (rst)
        accept |=> !done);
    assert_done_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);
endmodule

// File: rtl/bit_serial_adder.sv
module bit_serial_adder
    import serial_add_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_a,
    input  logic             load_b,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             start,
    input  logic             ser_in,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             shifting,
    output logic             done
);
    logic [WIDTH-1:0] a_q;
    logic [WIDTH-1:0] b_q;
    logic             carry_q;
    logic             accept;
    fa_out_t          fa;

    serial_seq_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .shifting (shifting),
        .done     (done),
        .accept   (accept)
    );

    fa_cell u_fa (
        .x  (a_q[0]),
        .y  (b_q[0]),
        .ci (carry_q),
        .o  (fa)
    );

    rshift_reg #(.WIDTH(WIDTH)) u_reg_a (
        .clk      (clk),
        .rst      (rst),
        .load     (load_a && !shifting),
        .load_val (a_in),
        .shift    (shifting),
        .ser_in   (fa.sum),
        .q        (a_q)
    );

    rshift_reg #(.WIDTH(WIDTH)) u_reg_b (
        .clk      (clk),
        .rst      (rst),
        .load     (load_b && !shifting),
        .load_val (b_in),
        .shift    (shifting),
        .ser_in   (ser_in),
        .q        (b_q)
    );

    always_ff @(posedge clk) begin
        if (rst)           carry_q <= 1'b0;
        else if (accept)   carry_q <= 1'b0;
        else if (shifting) carry_q <= fa.carry;
    end

    assign result    = a_q;
    assign carry_out = carry_q;

    assert_carry_clear_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(shifting) |-> !carry_q);
    assert_msb_sum_R10: assert property (@(posedge clk) disable iff (rst)
        shifting |=> (a_q[WIDTH-1] == ($past(a_q[0]) ^ $past(b_q[0]) ^ $past(carry_q))));
    assert_b_serial_R6: assert property (@(posedge clk) disable iff (rst)
        shifting |=> (b_q[WIDTH-1] == $past(ser_in)));
    assert_load_blocked_R8: assert property (@(posedge clk) disable iff (rst)
        (shifting && load_a) |=> (a_q[WIDTH-2:0] == $past(a_q[WIDTH-1:1])));
endmodule

// File: tb/bit_serial_adder_bench.sv
module bit_serial_adder_bench;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load_a = 1'b0, load_b = 1'b0, start = 1'b0, ser_in = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] result;
    logic         carry_out, shifting, done;
    int           checks = 0, errors = 0;

    always #4 clk = ~clk;

    bit_serial_adder #(.WIDTH(W)) u_bit_serial_adder (
        .clk(clk), .rst(rst), .load_a(load_a), .load_b(load_b),
        .a_in(a_in), .b_in(b_in), .start(start), .ser_in(ser_in),
        .result(result), .carry_out(carry_out), .shifting(shifting), .done(done)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // A is always loaded; B only when ld_b. ser drives B's serial input.
    // sk / lk: shift index at which a stray start / load_a pulse is injected (-1 = none).
    task automatic run_op(input int a, input int b, input bit ld_b, input int ser,
                          input int sk, input int lk);
        int sum;
        @(negedge clk);
        load_a = 1'b1; a_in = W'(a);
        load_b = ld_b; b_in = W'(b);
        @(negedge clk);
        load_a = 1'b0; load_b = 1'b0;
        check("R2 load A", int'(result), a);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R9 done cleared by start", int'(done), 0);
        check("R5 carry cleared at start", int'(carry_out), 0);
        sum = a + b;
        for (int k = 0; k < W; k++) begin
            ser_in = ser[k];
            start  = (k == sk);
            load_a = (k == lk);
            a_in   = ~W'(a);
            check("R3 shifting high", int'(shifting), 1);
            @(negedge clk);
            check("R10 msb sum bit", int'(result[W-1]), (sum >> k) & 1);
        end
        start = 1'b0; load_a = 1'b0; ser_in = 1'b0;
        check("R3 shifting low after WIDTH", int'(shifting), 0);
        check("R3 done high", int'(done), 1);
        check("R4 result", int'(result), sum % (1 << W));
        check("R4 carry_out", int'(carry_out), (sum >> W) & 1);
        @(negedge clk);
        check("R9 done held", int'(done), 1);
        check("R2 result held when idle", int'(result), sum % (1 << W));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 result", int'(result), 0);
        check("R1 carry", int'(carry_out), 0);
        check("R1 done", int'(done), 0);
        check("R1 shifting", int'(shifting), 0);

        // R10 worked example 0100 + 0111 -> 1011
        run_op(4, 7, 1'b1, 0, -1, -1);
        check("R10 example result", int'(result), 11);

        // R5 stale carry: carry-producing add then 0 + 0
        run_op(15, 1, 1'b1, 0, -1, -1);
        run_op(0, 0, 1'b1, 0, -1, -1);
        check("R5 no stale carry", int'(carry_out), 0);

        // R6 B takes serial bits: stream 1010 into B, then add with A = 0 and B not reloaded
        run_op(3, 3, 1'b1, 10, -1, -1);
        run_op(0, 10, 1'b0, 0, -1, -1);
        check("R6 serial B word", int'(result), 10);

        // R7 stray start mid-shift, R8 stray load_a mid-shift
        run_op(9, 6, 1'b1, 0, 1, -1);
        run_op(5, 12, 1'b1, 0, -1, 2);
        run_op(7, 7, 1'b1, 0, 0, 3);

        // R4 exhaustive sweep over all operand pairs
        for (int a = 0; a < (1 << W); a++)
            for (int b = 0; b < (1 << W); b++)
                run_op(a, b, 1'b1, a ^ b, -1, -1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule